// File: doc/BRIEF.md
# GPIO Port with Transition Interrupt

This block is a general-purpose I/O port of parameterised width. Each pin can be set as an input or an output. Input pins pass through a two-flop synchroniser, and a change in either direction on an input pin is recorded in an interrupt status register. Status bits that are also enabled drive a single interrupt output. Software-side access is a simple register port: a write strobe, a read strobe, a 3-bit address and data buses. Read data is registered and is valid on the cycle after the read strobe.

The interrupt output has two modes. In level mode it stays active while any enabled status bit is pending. In pulse mode it produces one fixed-width pulse when the port goes from nothing pending to something pending. Status clears only when it is read. Until that read, later transitions add status bits but do not produce a new pulse. The active polarity of the interrupt output is selectable. Output pins can also be driven in a pulse mode, where a written 1 returns to 0 by itself after a fixed number of cycles.

Register map (3-bit address): 0 input value (read-only), 1 output data, 2 input inversion, 3 direction (1 = output), 4 interrupt status (read clears), 5 interrupt enable, 6 control. Address 7 reads as 0. Control bits are: bit 0 selects interrupt pulse mode (1) or level mode (0); bit 1 selects an active-high interrupt (1) or an active-low one that idles high (0); bit 2 selects pulse mode for the output data bits.

Top module: `gpio_xint`

## Requirements
- R1: After reset, direction is all 0 (every pin is an input), pin_oe and pin_out are 0, rdata is 0, and int_out is 1, since the polarity bit resets to 0 and the active-low interrupt idles high.
- R2: A read of address 0 returns the synchronised level of each input-configured pin and 0 for each output-configured pin.
- R3: Each bit set in the inversion register (address 2) flips the matching bit of the value read at address 0.
- R4: pin_oe follows the direction register (address 3), and pin_out follows the output data register (address 1), which reads back at address 1.
- R5: A rising or falling change on an input-configured pin sets that pin's bit in the status register (address 4). A change on an output-configured pin sets nothing.
- R6: A read of address 4 returns the pending status bits and clears them.
- R7: In level mode (control bit 0 = 0), int_out is active while any status bit with its enable bit (address 5) set is pending, and it returns to idle after the status read.
- R8: A status bit whose enable bit is 0 does not activate int_out.
- R9: In pulse mode (control bit 0 = 1), each new interrupt event gives an int_out pulse exactly PULSE_LEN cycles wide.
- R10: While enabled status is still pending, further transitions produce no new pulse. The next pulse comes only after a status read and a new transition.
- R11: With control bit 1 = 1, int_out idles at 0 and is active at 1. With bit 1 = 0, it idles at 1 and is active at 0.
- R12: In output pulse mode (control bit 2 = 1), each output bit written as 1 drives pin_out high for exactly PULSE_LEN cycles. The bit then clears, and address 1 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | WIDTH | Write data |
| rdata | output | WIDTH | Registered read data, valid the cycle after rd_en |
| pin_in | input | WIDTH | Asynchronous pin input levels |
| pin_out | output | WIDTH | Pin output levels |
| pin_oe | output | WIDTH | Pin output enables (1 = drive) |
| int_out | output | 1 | Interrupt output |

## Verification
The bench uses the default WIDTH of 8 and PULSE_LEN of 8. At these values every interrupt and output pulse is short enough to count cycle by cycle, so the widths are checked exactly and not just seen to occur. An 8-bit port can hold inputs and outputs side by side in one direction pattern, so masking of output-configured pins is tested against input pins that change in the same run. The suppression of repeat pulses while status is pending, and the return of pulses after a read, are driven as one ordered sequence.

// File: rtl/gpio_xint_pkg.sv
package gpio_xint_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_IN   = 3'd0,
    RA_OUT  = 3'd1,
    RA_INV  = 3'd2,
    RA_DIR  = 3'd3,
    RA_STAT = 3'd4,
    RA_IEN  = 3'd5,
    RA_CTRL = 3'd6,
    RA_NONE = 3'd7
  } reg_addr_e;

  localparam int CB_INT_PULSE = 0;
  localparam int CB_INT_HIGH  = 1;
  localparam int CB_OUT_PULSE = 2;
  localparam int CTRL_W       = 3;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] edge_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic s1, s2, s3;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
        s3 <= 1'b0;
      end else begin
        s1 <= pin_i[i];
        s2 <= s1;
        s3 <= s2;
      end
    end
    assign sync_o[i] = s2;
    assign edge_o[i] = s2 ^ s3;
  end
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
  parameter int WIDTH     = 8,
  parameter int PULSE_LEN = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] edge_i,
  input  logic [WIDTH-1:0] in_mask,
  input  logic [WIDTH-1:0] ien,
  input  logic             rd_clr,
  input  logic             pulse_mode,
  input  logic             act_high,
  output logic [WIDTH-1:0] stat_o,
  output logic             int_o
);
  localparam int CW = $clog2(PULSE_LEN + 1);

  logic [WIDTH-1:0] stat;
  logic [WIDTH-1:0] new_ev;
  logic [CW-1:0]    cnt;
  logic             pend, pend_q, active;

  assign new_ev = edge_i & in_mask;
  assign pend   = |(stat & ien);
  assign active = pulse_mode ? (cnt != '0) : pend;
  assign stat_o = stat;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat   <= '0;
      pend_q <= 1'b0;
      cnt    <= '0;
      int_o  <= 1'b1;
    end else begin
      stat   <= rd_clr ? new_ev : (stat | new_ev);
      pend_q <= pend;
      if (pend && !pend_q)
        cnt <= CW'(PULSE_LEN);
      else if (cnt != '0)
        cnt <= cnt - 1'b1;
      int_o <= act_high ? active : !active;
    end
  end

  // R5
  stat_set_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat & ~$past(stat) & ~$past(new_ev)) == '0));

  // R6
  stat_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && new_ev == '0) |=> (stat == '0));

  // R10
  hold_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0 && pend_q && pend) |=> (cnt == CW'($past(cnt) - 1'b1)));
endmodule

// File: rtl/gpio_outdrv.sv
module gpio_outdrv #(
  parameter int WIDTH     = 8,
  parameter int PULSE_LEN = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pulse_mode,
  output logic [WIDTH-1:0] data_o
);
  localparam int CW = $clog2(PULSE_LEN + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_o <= '0;
      cnt    <= '0;
    end else if (wr) begin
      data_o <= wdata;
      cnt    <= pulse_mode ? CW'(PULSE_LEN) : '0;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
      if (cnt == CW'(1))
        data_o <= '0;
    end
  end

  // R12
  out_pulse_end_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr && cnt == CW'(1)) |=> (data_o == '0));
endmodule

// File: rtl/gpio_xint.sv
module gpio_xint
  import gpio_xint_pkg::*;
#(
  parameter int WIDTH     = 8,
  parameter int PULSE_LEN = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe,
  output logic              int_out
);
  reg_addr_e         ra;
  logic [WIDTH-1:0]  sync_v, edge_v, stat_v, out_v;
  logic [WIDTH-1:0]  inv_r, dir_r, ien_r, in_val;
  logic [CTRL_W-1:0] ctrl_r;
  logic              rd_clr;

  assign ra     = reg_addr_e'(addr);
  assign in_val = (sync_v ^ inv_r) & ~dir_r;
  assign rd_clr = rd_en && (ra == RA_STAT);

  gpio_sync #(.WIDTH(WIDTH)) u_sync (
    .clk(clk), .rst(rst), .pin_i(pin_in), .sync_o(sync_v), .edge_o(edge_v)
  );

  gpio_irq #(.WIDTH(WIDTH), .PULSE_LEN(PULSE_LEN)) u_irq (
    .clk(clk), .rst(rst), .edge_i(edge_v), .in_mask(~dir_r), .ien(ien_r),
    .rd_clr(rd_clr), .pulse_mode(ctrl_r[CB_INT_PULSE]),
    .act_high(ctrl_r[CB_INT_HIGH]), .stat_o(stat_v), .int_o(int_out)
  );

  gpio_outdrv #(.WIDTH(WIDTH), .PULSE_LEN(PULSE_LEN)) u_out (
    .clk(clk), .rst(rst), .wr(wr_en && (ra == RA_OUT)), .wdata(wdata),
    .pulse_mode(ctrl_r[CB_OUT_PULSE]), .data_o(out_v)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      inv_r  <= '0;
      dir_r  <= '0;
      ien_r  <= '0;
      ctrl_r <= '0;
    end else if (wr_en) begin
      case (ra)
        RA_INV:  inv_r  <= wdata;
        RA_DIR:  dir_r  <= wdata;
        RA_IEN:  ien_r  <= wdata;
        RA_CTRL: ctrl_r <= wdata[CTRL_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (ra)
        RA_IN:   rdata <= in_val;
        RA_OUT:  rdata <= out_v;
        RA_INV:  rdata <= inv_r;
        RA_DIR:  rdata <= dir_r;
        RA_STAT: rdata <= stat_v;
        RA_IEN:  rdata <= ien_r;
        RA_CTRL: rdata <= WIDTH'(ctrl_r);
        default: rdata <= '0;
      endcase
    end
  end

  assign pin_out = out_v;
  assign pin_oe  = dir_r;

  // R4
  oe_dir_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ra == RA_DIR) |=> (pin_oe == $past(wdata)));
endmodule

// File: tb/gpio_xint_tb.sv
`timescale 1ns/1ps
module gpio_xint_tb;
  localparam int W = 8;
  localparam int PL = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]   addr = '0;
  logic [W-1:0] wdata = '0, pin_in = '0;
  logic [W-1:0] rdata, pin_out, pin_oe;
  logic         int_out;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  gpio_xint #(.WIDTH(W), .PULSE_LEN(PL)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .int_out(int_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic toggle(input logic [W-1:0] m);
    @(negedge clk);
    pin_in = pin_in ^ m;
    repeat (6) @(negedge clk);
  endtask

  function automatic int count_int(input logic lvl);
    return 0;
  endfunction

  task automatic count_pulse(input logic act_lvl, output int n);
    n = 0;
    for (int i = 0; i < 24; i++) begin
      if (int_out == act_lvl) n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk("R1 dir", int'(pin_oe), 0);
    chk("R1 out", int'(pin_out), 0);
    chk("R1 rdata", int'(rdata), 0);
    chk("R1 int idle", int'(int_out), 1);
  endtask

  task automatic t_input;
    logic [W-1:0] d;
    wr(3'd3, 8'hF0);
    pin_in = 8'h5A;
    repeat (4) @(negedge clk);
    rd(3'd0, d);
    chk("R2 input masked", int'(d), 'h0A);
    wr(3'd2, 8'h0F);
    rd(3'd0, d);
    chk("R3 inverted", int'(d), 'h05);
    wr(3'd2, 8'h00);
    rd(3'd4, d);
    chk("R5 changes on inputs seen", int'(d), 'h0A);
  endtask

  task automatic t_output;
    logic [W-1:0] d;
    wr(3'd1, 8'hA5);
    chk("R4 oe", int'(pin_oe), 'hF0);
    chk("R4 pin_out", int'(pin_out), 'hA5);
    rd(3'd1, d);
    chk("R4 readback", int'(d), 'hA5);
    toggle(8'h80);
    rd(3'd4, d);
    chk("R5 output pin ignored", int'(d), 0);
    wr(3'd3, 8'h00);
  endtask

  task automatic t_level;
    logic [W-1:0] d;
    wr(3'd5, 8'h01);
    toggle(8'h01);
    chk("R7 level active low", int'(int_out), 0);
    rd(3'd4, d);
    chk("R6 status read", int'(d), 'h01);
    repeat (2) @(negedge clk);
    chk("R7 idle after read", int'(int_out), 1);
    rd(3'd4, d);
    chk("R6 status cleared", int'(d), 0);
    toggle(8'h02);
    chk("R8 disabled bit no int", int'(int_out), 1);
    rd(3'd4, d);
    chk("R8 status still set", int'(d), 'h02);
  endtask

  task automatic t_polarity;
    logic [W-1:0] d;
    wr(3'd6, 8'h02);
    repeat (2) @(negedge clk);
    chk("R11 idle low", int'(int_out), 0);
    toggle(8'h01);
    chk("R11 active high", int'(int_out), 1);
    rd(3'd4, d);
    repeat (2) @(negedge clk);
    chk("R11 back to idle", int'(int_out), 0);
  endtask

  task automatic t_pulse;
    logic [W-1:0] d;
    int n;
    wr(3'd6, 8'h00);
    wr(3'd5, 8'hFF);
    wr(3'd6, 8'h01);
    repeat (2) @(negedge clk);
    @(negedge clk);
    pin_in = pin_in ^ 8'h04;
    count_pulse(1'b0, n);
    chk("R9 pulse width", n, PL);
    @(negedge clk);
    pin_in = pin_in ^ 8'h08;
    count_pulse(1'b0, n);
    chk("R10 no pulse while pending", n, 0);
    rd(3'd4, d);
    chk("R10 status accumulated", int'(d), 'h0C);
    @(negedge clk);
    pin_in = pin_in ^ 8'h08;
    count_pulse(1'b0, n);
    chk("R10 pulse after read", n, PL);
    rd(3'd4, d);
  endtask

  task automatic t_outpulse;
    logic [W-1:0] d;
    int n;
    wr(3'd3, 8'h0F);
    wr(3'd6, 8'h04);
    wr(3'd1, 8'h05);
    n = 0;
    for (int i = 0; i < 20; i++) begin
      if (pin_out[0]) n++;
      @(negedge clk);
    end
    chk("R12 output pulse width", n, PL);
    rd(3'd1, d);
    chk("R12 register cleared", int'(d), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_input();
    t_output();
    t_level();
    t_polarity();
    t_pulse();
    t_outpulse();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule